// File: doc/BRIEF.md
# Serial Byte Transfer Bit Sequencer

This block paces one byte on a two-wire serial bus. Software loads a small count field that sets how many data bits the next transfer carries, and may also turn on an extra acknowledge clock. The block counts qualified rising edges of the serial clock. It shifts the data bits into a data register, most significant bit first. When the last clock of the transfer has been seen, it raises a transfer-done pulse and a level interrupt request. The count field then clears itself, so the next byte is a full-width byte unless software sets the field again.

A START condition restarts the bit position and clears the count field. The address byte that follows is therefore always full width. A global enable governs the whole block. While it is low, the bus pins are released, the status flags take fixed values, and writes to the data register and serial clock edges have no effect.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset, pin_oe, xfer_done, irq, bus_busy and arb_lost are 0, req_idle is 1, and cnt_field, bit_pos and data_q are 0.
- R2: A transfer has N data bits, where N is cnt_field when it is nonzero and 8 when cnt_field is 000. xfer_done is high for the one cycle that follows the clock edge at which the last qualified scl_rise of the transfer is sampled, and bit_pos counts the edges already taken (0 to 8).
- R3: When the acknowledge enable (cfg_ack) is 1, a transfer takes N+1 scl_rise edges. irq goes to 1 together with xfer_done and stays at 1 until an accepted data write clears it.
- R4: At the end of a transfer, cnt_field returns to 000 in the same cycle that xfer_done is high. This clear takes priority over a control write in the same cycle.
- R5: A start_det pulse while enabled clears cnt_field and bit_pos, so the next transfer takes 8 data bits. It also sets bus_busy, and a stop_det pulse clears bus_busy again.
- R6: On each scl_rise that carries a data bit, data_q shifts left by one and takes sda_in into bit 0. The acknowledge edge does not shift. An accepted dat_we loads dat_wdata instead of shifting.
- R7: While the enable is 0, pin_oe is 0, req_idle is 1, and bus_busy, arb_lost, irq and xfer_done are 0.
- R8: While the enable is 0, dat_we leaves data_q unchanged, and scl_rise and start_det leave bit_pos at 0 and raise no xfer_done.
- R9: An arb_det pulse while enabled sets arb_lost. A start_det pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable value written by cfg_we |
| cfg_ack | input | 1 | Acknowledge-clock enable written by cfg_we |
| cfg_cnt | input | CNT_W | Count field value written by cfg_we |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 2**CNT_W | Data register write value |
| sda_in | input | 1 | Serial data sampled on data-bit edges |
| scl_rise | input | 1 | One-cycle pulse for a detected serial clock rising edge |
| start_det | input | 1 | One-cycle pulse for a detected START condition |
| stop_det | input | 1 | One-cycle pulse for a detected STOP condition |
| arb_det | input | 1 | One-cycle pulse for detected lost arbitration |
| irq | output | 1 | Interrupt request level |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |
| req_idle | output | 1 | 1 when no request is pending |
| bus_busy | output | 1 | Bus busy flag |
| arb_lost | output | 1 | Arbitration lost flag |
| pin_oe | output | 1 | Pin drive enable; 0 releases the pins |
| cnt_field | output | CNT_W | Current count field |
| bit_pos | output | CNT_W+2 | Edges taken in the current transfer |
| data_q | output | 2**CNT_W | Data shift register |

## Verification
The assertions assume that scl_rise, start_det, stop_det and arb_det are single-cycle pulses from an edge detector. They also assume that software does not rewrite the count field in the middle of a transfer to a value below the edges already taken. The bit-position bound relies on that. The random stimulus sends control writes only in cycles with no bus event, and control writes are sparse. Enable is written to 1 far more often than to 0, so long transfers, collisions between START, STOP and clock edges, and disabled stretches all occur.

// File: rtl/i2c_byte_seq_pkg.sv
package i2c_byte_seq_pkg;

  // Data bits carried by one transfer: zero selects the full width.
  function automatic int unsigned data_bits(int unsigned cnt, int unsigned full);
    return (cnt == 0) ? full : cnt;
  endfunction

  // Serial clocks taken by one transfer, acknowledge clock included.
  function automatic int unsigned xfer_len(int unsigned cnt, logic ack,
                                           int unsigned full);
    return data_bits(cnt, full) + (ack ? 1 : 0);
  endfunction

endpackage

// File: rtl/bc_ctl_reg.sv
module bc_ctl_reg #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_ack,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             clr_cnt,
  output logic             en_q,
  output logic             ack_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= cfg_en;
        ack_q <= cfg_ack;
        cnt_q <= cfg_cnt;
      end
      // End of transfer or START wins over a same-cycle write.
      if (clr_cnt) cnt_q <= '0;
    end
  end
endmodule

// File: rtl/bc_bit_seq.sv
module bc_bit_seq
  import i2c_byte_seq_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             scl_rise,
  input  logic             ack,
  input  logic [CNT_W-1:0] cnt,
  output logic [LEN_W-1:0] pos_q,
  output logic             done_q,
  output logic             evt_done,
  output logic             evt_data,
  output logic [LEN_W-1:0] len
);
  localparam int unsigned FULL = 1 << CNT_W;

  logic [LEN_W-1:0] bits;
  logic [LEN_W-1:0] pos_inc;
  logic             qual;

  always_comb begin
    len      = LEN_W'(xfer_len(32'(cnt), ack, FULL));
    bits     = LEN_W'(data_bits(32'(cnt), FULL));
    pos_inc  = pos_q + LEN_W'(1);
    qual     = en & scl_rise & ~start;
    evt_done = qual & (pos_inc >= len);
    evt_data = qual & (pos_q < bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (!en || start) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (scl_rise) begin
      done_q <= evt_done;
      pos_q  <= evt_done ? '0 : pos_inc;
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bc_flags.sv
module bc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic stop,
  input  logic arb_det,
  input  logic done_evt,
  input  logic dat_wr,
  output logic idle_q,
  output logic busy_q,
  output logic arb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      busy_q <= 1'b0;
      arb_q  <= 1'b0;
    end else if (!en) begin
      idle_q <= 1'b1;
      busy_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (done_evt)    idle_q <= 1'b0;
      else if (dat_wr) idle_q <= 1'b1;
      if (start)       busy_q <= 1'b1;
      else if (stop)   busy_q <= 1'b0;
      if (start)       arb_q  <= 1'b0;
      else if (arb_det) arb_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bc_shreg.sv
module bc_shreg #(
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DAT_W-1:0] wdata,
  input  logic             shift,
  input  logic             sda,
  output logic [DAT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr)    q <= wdata;
    else if (shift) q <= {q[DAT_W-2:0], sda};
  end
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter  int CNT_W = 3,
  localparam int DAT_W = 1 << CNT_W,
  localparam int LEN_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_ack,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             dat_we,
  input  logic [DAT_W-1:0] dat_wdata,
  input  logic             sda_in,
  input  logic             scl_rise,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             arb_det,
  output logic             irq,
  output logic             xfer_done,
  output logic             req_idle,
  output logic             bus_busy,
  output logic             arb_lost,
  output logic             pin_oe,
  output logic [CNT_W-1:0] cnt_field,
  output logic [LEN_W-1:0] bit_pos,
  output logic [DAT_W-1:0] data_q
);
  logic             en_q, ack_q;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_done, evt_data, done_q;
  logic [LEN_W-1:0] len;
  logic             dat_wr, clr_cnt;
  logic             idle_q, busy_q, arb_q;

  assign dat_wr  = dat_we & en_q;
  assign clr_cnt = en_q & (start_det | evt_done);

  bc_ctl_reg #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_ack(cfg_ack), .cfg_cnt(cfg_cnt), .clr_cnt(clr_cnt),
    .en_q(en_q), .ack_q(ack_q), .cnt_q(cnt_q)
  );

  bc_bit_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start_det),
    .scl_rise(scl_rise), .ack(ack_q), .cnt(cnt_q), .pos_q(bit_pos),
    .done_q(done_q), .evt_done(evt_done), .evt_data(evt_data), .len(len)
  );

  bc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start_det),
    .stop(stop_det), .arb_det(arb_det), .done_evt(evt_done),
    .dat_wr(dat_wr), .idle_q(idle_q), .busy_q(busy_q), .arb_q(arb_q)
  );

  bc_shreg #(.DAT_W(DAT_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .wr(dat_wr), .wdata(dat_wdata),
    .shift(evt_data), .sda(sda_in), .q(data_q)
  );

  // Flags are masked by the enable so they take their fixed values at once.
  assign pin_oe    = en_q;
  assign cnt_field = cnt_q;
  assign req_idle  = idle_q | ~en_q;
  assign irq       = ~req_idle;
  assign bus_busy  = busy_q & en_q;
  assign arb_lost  = arb_q & en_q;
  assign xfer_done = done_q & en_q;
endmodule

// File: rtl/i2c_byte_seq_chk.sv
module i2c_byte_seq_chk #(
  parameter int CNT_W = 3,
  parameter int DAT_W = 8,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             irq,
  input logic             xfer_done,
  input logic             req_idle,
  input logic             bus_busy,
  input logic             arb_lost,
  input logic             pin_oe,
  input logic [CNT_W-1:0] cnt_field,
  input logic [LEN_W-1:0] bit_pos,
  input logic [DAT_W-1:0] data_q
);
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= LEN_W'(DAT_W)); // R2
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> irq); // R3
  AST_DONE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (cnt_field == '0)); // R4
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && start_det) |=> (cnt_field == '0 && bit_pos == '0 && !xfer_done)); // R5
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> (req_idle && !bus_busy && !arb_lost && !xfer_done)); // R7
  AST_OFF_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |=> $stable(data_q)); // R8
endmodule

bind i2c_byte_seq i2c_byte_seq_chk #(.CNT_W(CNT_W), .DAT_W(DAT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .irq(irq),
  .xfer_done(xfer_done), .req_idle(req_idle), .bus_busy(bus_busy),
  .arb_lost(arb_lost), .pin_oe(pin_oe), .cnt_field(cnt_field),
  .bit_pos(bit_pos), .data_q(data_q)
);

// File: tb/i2c_byte_seq_tb.sv
module i2c_byte_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_en, cfg_ack;
  logic [2:0] cfg_cnt;
  logic       dat_we;
  logic [7:0] dat_wdata;
  logic       sda_in, scl_rise, start_det, stop_det, arb_det;
  logic       irq, xfer_done, req_idle, bus_busy, arb_lost, pin_oe;
  logic [2:0] cnt_field;
  logic [4:0] bit_pos;
  logic [7:0] data_q;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side model state
  bit       m_en, m_ack, m_done, m_idle, m_busy, m_arb;
  bit [2:0] m_cnt;
  int       m_pos;
  bit [7:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_seq u_dut (.*);

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int exp_bits(bit [2:0] c);
    return (c == 3'd0) ? 8 : int'(c);
  endfunction

  task automatic model_edge();
    int  len = exp_bits(m_cnt) + (m_ack ? 1 : 0);
    int  old_pos = m_pos;
    bit  was_en = m_en;
    bit  done = 1'b0;
    if (!was_en) begin
      m_pos = 0; m_idle = 1; m_busy = 0; m_arb = 0;
    end else begin
      if (start_det) begin
        m_pos = 0; m_busy = 1; m_arb = 0;
      end else begin
        if (scl_rise) begin
          if (old_pos + 1 >= len) begin done = 1; m_pos = 0; end
          else m_pos = old_pos + 1;
        end
        if (stop_det) m_busy = 0;
        if (arb_det)  m_arb = 1;
      end
      if (dat_we) m_data = dat_wdata;
      else if (scl_rise && !start_det && old_pos < exp_bits(m_cnt))
        m_data = {m_data[6:0], sda_in};
      if (done) m_idle = 0;
      else if (dat_we) m_idle = 1;
    end
    if (cfg_we) begin m_en = cfg_en; m_ack = cfg_ack; m_cnt = cfg_cnt; end
    if (was_en && (start_det || done)) m_cnt = 3'd0;
    m_done = done;
  endtask

  task automatic compare_all();
    chk("R7 pin_oe", int'(pin_oe), int'(m_en));
    chk("R2 xfer_done", int'(xfer_done), int'(m_done && m_en));
    chk("R2 bit_pos", int'(bit_pos), m_pos);
    chk("R3 irq", int'(irq), int'(m_en && !m_idle));
    chk("R7 req_idle", int'(req_idle), int'(m_idle || !m_en));
    chk("R5 bus_busy", int'(bus_busy), int'(m_busy && m_en));
    chk("R9 arb_lost", int'(arb_lost), int'(m_arb && m_en));
    chk("R4 cnt_field", int'(cnt_field), int'(m_cnt));
    chk("R6 data_q", int'(data_q), int'(m_data));
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_en = 0; cfg_ack = 0; cfg_cnt = 0; dat_we = 0;
    dat_wdata = 0; sda_in = 0; scl_rise = 0; start_det = 0;
    stop_det = 0; arb_det = 0;
  endtask

  // Inputs already set at a falling edge; take one rising edge and check.
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic cfg(bit en, bit ack, bit [2:0] c);
    cfg_we = 1; cfg_en = en; cfg_ack = ack; cfg_cnt = c; tick();
  endtask

  task automatic clk_bit(bit d);
    scl_rise = 1; sda_in = d; tick();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    m_en = 0; m_ack = 0; m_cnt = 0; m_pos = 0; m_done = 0;
    m_idle = 1; m_busy = 0; m_arb = 0; m_data = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 req_idle", int'(req_idle), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cnt_field", int'(cnt_field), 0);
    chk("R1 data_q", int'(data_q), 0);
    rst_n = 1;
    @(negedge clk);

    // R8 disabled: write and clocks ignored
    dat_we = 1; dat_wdata = 8'h77; tick();
    chk("R8 data held", int'(data_q), 0);
    clk_bit(1);
    chk("R8 no position", int'(bit_pos), 0);

    cfg(1, 0, 3'd0);
    dat_we = 1; dat_wdata = 8'hA5; tick();
    chk("R6 load", int'(data_q), 8'hA5);
    chk("R3 irq clear", int'(irq), 0);

    // R2 full-width byte 0x3C
    for (int i = 7; i >= 1; i--) begin
      clk_bit(8'h3C >> i);
      chk("R2 no early done", int'(xfer_done), 0);
    end
    clk_bit(1'b0);
    chk("R2 done after 8", int'(xfer_done), 1);
    chk("R3 irq set", int'(irq), 1);
    chk("R4 field cleared", int'(cnt_field), 0);
    chk("R6 shifted", int'(data_q), 8'h3C);
    tick();
    chk("R2 done one cycle", int'(xfer_done), 0);
    chk("R3 irq held", int'(irq), 1);

    // R3 three bits plus acknowledge
    cfg(1, 1, 3'd3);
    clk_bit(1); clk_bit(0); clk_bit(1);
    chk("R3 no done before ack", int'(xfer_done), 0);
    clk_bit(1);
    chk("R3 done after ack", int'(xfer_done), 1);
    chk("R6 ack edge not shifted", int'(data_q), 8'hE5);
    chk("R4 field cleared ack", int'(cnt_field), 0);

    // R5 START mid-transfer, then full byte without ack
    cfg(1, 0, 3'd5);
    clk_bit(0); clk_bit(0);
    start_det = 1; tick();
    chk("R5 field zero", int'(cnt_field), 0);
    chk("R5 pos zero", int'(bit_pos), 0);
    chk("R5 busy", int'(bus_busy), 1);
    arb_det = 1; tick();
    chk("R9 arb set", int'(arb_lost), 1);
    repeat (7) clk_bit(1);
    chk("R5 not done at 7", int'(xfer_done), 0);
    clk_bit(1);
    chk("R5 done at 8", int'(xfer_done), 1);
    start_det = 1; tick();
    chk("R9 arb cleared by start", int'(arb_lost), 0);
    stop_det = 1; tick();
    chk("R5 stop clears busy", int'(bus_busy), 0);

    // R7 disable forces flags
    arb_det = 1; start_det = 0; tick();
    cfg(0, 0, 3'd0);
    chk("R7 released", int'(pin_oe), 0);
    chk("R7 idle", int'(req_idle), 1);
    chk("R7 arb", int'(arb_lost), 0);

    // constrained random
    begin
      int unsigned seed = 32'd20240611;
      void'($urandom(seed));
    end
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(99) < 4) begin
        cfg_we = 1; cfg_en = ($urandom_range(9) != 0);
        cfg_ack = $urandom_range(1); cfg_cnt = 3'($urandom_range(7));
      end else begin
        scl_rise  = ($urandom_range(1) == 1);
        sda_in    = $urandom_range(1);
        start_det = ($urandom_range(99) < 3);
        stop_det  = ($urandom_range(99) < 3);
        arb_det   = ($urandom_range(99) < 3);
        dat_we    = ($urandom_range(99) < 5);
        dat_wdata = 8'($urandom());
      end
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule